// File: doc/BRIEF.md
# Mid-Bin Reference Calibrator for Coarse-Quantizer Identification

This block gets a digital voltage loop ready for a short identification phase. In that phase the duty-ratio quantizer is made deliberately coarse so that the loop settles into a limit cycle. The block watches the high-resolution duty control word and the digital voltage reference. When a start request arrives, it samples the low bits of the duty word that the coarse quantizer is about to discard. From them it computes the offset that moves those bits to the centre code of a coarse step. It adds that offset to the reference, clamping at the top of the reference range. It then tells the modulator how many low bits to drop.

The control value therefore sits halfway between two coarse duty codes. That gives a symmetric oscillation with zero offset, including at operating points where a coarse step would otherwise settle inside the zero-error bin. Two coarse settings are provided: the normal one drops three bits of the ten-bit duty word, and a light-load option drops only two. When the phase ends, the reference that was in force before the phase is written back in the same cycle that full resolution returns.

Top module: `coarse_ref_calibrator`

## Requirements
- R1: While rst_n is low and after its release, ref_o is 0, drop_o is 0 (full resolution), busy_o is 0 and done_o is 0.
- R2: While idle, ref_o shows the value ref_i had at the previous rising clock edge, and drop_o stays 0.
- R3: A start_i sampled high while idle with light_i low captures k = 3 and the low field L = duty_i[2:0]. Two edges later ref_o equals the captured reference plus (4 − L) mod 8, and drop_o equals 3. Example: L = 001 gives +3, L = 101 gives +7, L = 100 gives +0.
- R4: The same sequence with light_i high uses k = 2, L = duty_i[1:0] and offset (2 − L) mod 4, and drop_o equals 2.
- R5: The adjusted reference saturates at 2^12 − 1 instead of wrapping.
- R6: done_o is high for exactly one cycle: the cycle after the adjusted reference and the nonzero drop_o first appear.
- R7: A stop_i sampled high after the done pulse, at the next edge, restores ref_o to the reference captured at start, sets drop_o to 0 and clears busy_o. After that, idle tracking resumes.
- R8: A start_i sampled while busy_o is high is ignored: no new capture, no change to ref_o, no new done pulse.
- R9: busy_o rises at the edge after start_i is sampled and stays high until the restoring edge. A stop_i sampled before the done pulse has been seen, or while idle, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | 10 | High-resolution duty control word |
| ref_i | input | 12 | Digital voltage reference from the loop |
| start_i | input | 1 | Request to enter identification |
| light_i | input | 1 | Selects the finer coarse setting (two dropped bits) |
| stop_i | input | 1 | Request to leave identification |
| ref_o | output | 12 | Reference applied to the loop |
| drop_o | output | 2 | Number of low duty bits the modulator discards; 0 means full resolution |
| busy_o | output | 1 | Calibration phase in progress |
| done_o | output | 1 | One-cycle pulse once the adjusted reference and coarse setting are in place |

## Verification
The bench builds the block with its defaults: a 10-bit duty word, a 12-bit reference, three dropped bits in the normal setting and two in the light-load setting. With these values every low-field code in both settings can be reached with a few starts. That includes the wrap case, where the field lies above the centre code, and the zero-offset case, where it already equals the centre code. The 12-bit reference is narrow enough that the saturation edge can be hit directly by starting from a reference a few codes below full scale.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_HOLD   = 2'd3
    } cal_state_t;
endpackage

// File: rtl/cal_mid_offset.sv
module cal_mid_offset #(
    parameter int MAX_DROP = 3,
    localparam int CNT_W = $clog2(MAX_DROP + 1)
) (
    input  logic [MAX_DROP-1:0] low_i,
    input  logic [CNT_W-1:0]    drop_i,
    output logic [MAX_DROP-1:0] corr_o
);
    logic [MAX_DROP-1:0] mask;
    logic [MAX_DROP-1:0] centre;
    logic [MAX_DROP-1:0] field;

    // mask keeps the bits the coarse quantizer drops; centre is the mid-step code
    always_comb begin
        mask   = '0;
        centre = '0;
        for (int b = 0; b < MAX_DROP; b++) begin
            if (CNT_W'(b) < drop_i)       mask[b]   = 1'b1;
            if (CNT_W'(b + 1) == drop_i)  centre[b] = 1'b1;
        end
        field  = low_i & mask;
        corr_o = (centre - field) & mask;
    end
endmodule

// File: rtl/cal_sat_add.sv
module cal_sat_add #(
    parameter int A_W = 12,
    parameter int B_W = 3
) (
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic [A_W-1:0] sum_o
);
    logic [A_W:0] wide;

    always_comb begin
        wide  = {1'b0, a_i} + (A_W + 1)'(b_i);
        sum_o = wide[A_W] ? {A_W{1'b1}} : wide[A_W-1:0];
    end
endmodule

// File: rtl/coarse_ref_calibrator.sv
module coarse_ref_calibrator
    import cal_pkg::*;
#(
    parameter int DUTY_W     = 10,
    parameter int REF_W      = 12,
    parameter int DROP_ID    = 3,
    parameter int DROP_LIGHT = 2,
    localparam int CNT_W = $clog2(DROP_ID + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [REF_W-1:0]  ref_i,
    input  logic              start_i,
    input  logic              light_i,
    input  logic              stop_i,
    output logic [REF_W-1:0]  ref_o,
    output logic [CNT_W-1:0]  drop_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        cal_state_t         state;
        logic [REF_W-1:0]   refv;
        logic [REF_W-1:0]   saved;
        logic [DROP_ID-1:0] corr;
        logic [CNT_W-1:0]   kdrop;
        logic [CNT_W-1:0]   drop;
        logic               done;
    } cal_regs_t;

    cal_regs_t regs_q, regs_d;

    logic [CNT_W-1:0]   k_sel;
    logic [DROP_ID-1:0] corr_w;
    logic [REF_W-1:0]   adj_w;
    logic               unused_duty_hi;

    assign unused_duty_hi = ^duty_i[DUTY_W-1:DROP_ID];
    assign k_sel = light_i ? CNT_W'(DROP_LIGHT) : CNT_W'(DROP_ID);

    cal_mid_offset #(.MAX_DROP(DROP_ID)) u_offset (
        .low_i  (duty_i[DROP_ID-1:0]),
        .drop_i (k_sel),
        .corr_o (corr_w)
    );

    cal_sat_add #(.A_W(REF_W), .B_W(DROP_ID)) u_add (
        .a_i   (regs_q.saved),
        .b_i   (regs_q.corr),
        .sum_o (adj_w)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                regs_d.refv = ref_i;
                if (start_i) begin
                    regs_d.saved = ref_i;
                    regs_d.corr  = corr_w;
                    regs_d.kdrop = k_sel;
                    regs_d.state = ST_CALC;
                end
            end
            ST_CALC: begin
                regs_d.refv  = adj_w;
                regs_d.drop  = regs_q.kdrop;
                regs_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                regs_d.done  = 1'b1;
                regs_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (stop_i) begin
                    regs_d.refv  = regs_q.saved;
                    regs_d.drop  = '0;
                    regs_d.state = ST_IDLE;
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ref_o  = regs_q.refv;
    assign drop_o = regs_q.drop;
    assign busy_o = (regs_q.state != ST_IDLE);
    assign done_o = regs_q.done;

    assert_idle_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> drop_o == '0);
    assert_adjust_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_SETTLE) |-> (ref_o >= regs_q.saved));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_coarse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (drop_o != '0 && busy_o));
    assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_HOLD && stop_i) |=>
            (ref_o == $past(regs_q.saved) && drop_o == '0 && !busy_o));
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(regs_q.saved));
endmodule

// File: tb/coarse_ref_calibrator_test.sv
`timescale 1ns/1ps
module coarse_ref_calibrator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  duty_i = '0;
    logic [11:0] ref_i = '0;
    logic        start_i = 1'b0, light_i = 1'b0, stop_i = 1'b0;
    logic [11:0] ref_o;
    logic [1:0]  drop_o;
    logic        busy_o, done_o;

    int total = 0, bad = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;
    string tag = "R1";

    // behavioural reference model
    int m_st = 0, m_ref = 0, m_saved = 0, m_corr = 0, m_k = 0, m_drop = 0;
    bit m_done = 1'b0;

    always #4 clk = ~clk;

    coarse_ref_calibrator uut (
        .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .ref_i(ref_i),
        .start_i(start_i), .light_i(light_i), .stop_i(stop_i),
        .ref_o(ref_o), .drop_o(drop_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int offset_of(int duty, int k);
        int span = 1 << k;
        int mid  = span / 2;
        return ((mid - (duty % span)) % span + span) % span;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ref = 0; m_saved = 0; m_corr = 0; m_k = 0; m_drop = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_st)
                0: begin
                    m_ref = ref_i;
                    if (start_i) begin
                        m_saved = ref_i;
                        m_k = light_i ? 2 : 3;
                        m_corr = offset_of(duty_i, m_k);
                        m_st = 1;
                    end
                end
                1: begin
                    m_ref = (m_saved + m_corr > 4095) ? 4095 : m_saved + m_corr;
                    m_drop = m_k;
                    m_st = 2;
                end
                2: begin m_done = 1; m_st = 3; end
                default: if (stop_i) begin m_ref = m_saved; m_drop = 0; m_st = 0; end
            endcase
        end
    end

    task automatic check(string t, string what, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !finished) begin
            check(tag, "ref_o", int'(ref_o), m_ref);
            check(tag, "drop_o", int'(drop_o), m_drop);
            check(tag, "busy_o", int'(busy_o), (m_st != 0) ? 1 : 0);
            check(tag, "done_o", int'(done_o), int'(m_done));
        end
    end

    task automatic run_cal(int r, int d, bit lt, int exp_ref, int exp_drop, string t);
        tag = t;
        @(negedge clk); ref_i = 12'(r); duty_i = 10'(d); light_i = lt; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(t, "busy after start R9", int'(busy_o), 1);
        @(negedge clk);
        check(t, "adjusted ref", int'(ref_o), exp_ref);
        check(t, "drop", int'(drop_o), exp_drop);
        @(negedge clk);
        check("R6", "done pulse", int'(done_o), 1);
        @(negedge clk);
        check("R6", "done cleared", int'(done_o), 0);
    endtask

    task automatic end_cal(int exp_saved, int next_ref);
        tag = "R7";
        @(negedge clk); ref_i = 12'(next_ref); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check("R7", "restored ref", int'(ref_o), exp_saved);
        check("R7", "full resolution", int'(drop_o), 0);
        check("R9", "busy cleared", int'(busy_o), 0);
        @(negedge clk);
        check("R2", "tracking resumed", int'(ref_o), next_ref);
    endtask

    initial begin
        @(negedge clk); chk_en = 1'b1;
        check("R1", "reset ref", int'(ref_o), 0);
        check("R1", "reset drop", int'(drop_o), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tag = "R2";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); ref_i = 12'(300 + 17 * i); stop_i = (i == 2);
        end
        @(negedge clk); stop_i = 1'b0;
        check("R2", "idle follows ref", int'(ref_o), 351);

        run_cal(100, 10'h041, 1'b0, 103, 3, "R3");
        tag = "R9";
        @(negedge clk); ref_i = 12'd200;
        end_cal(100, 200);

        run_cal(800, 10'h0A5, 1'b0, 807, 3, "R3");
        end_cal(800, 10);
        run_cal(640, 10'h2C4, 1'b0, 640, 3, "R3");
        end_cal(640, 11);

        run_cal(500, 10'h3F3, 1'b1, 503, 2, "R4");
        end_cal(500, 12);
        run_cal(900, 10'h100, 1'b1, 902, 2, "R4");
        end_cal(900, 13);

        run_cal(4093, 10'h000, 1'b0, 4095, 3, "R5");
        end_cal(4093, 14);

        run_cal(1000, 10'h001, 1'b0, 1003, 3, "R8");
        tag = "R8";
        @(negedge clk); ref_i = 12'd2000; duty_i = 10'h005; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R8", "ref unchanged", int'(ref_o), 1003);
        @(negedge clk);
        check("R8", "no new done", int'(done_o), 0);
        end_cal(1000, 15);

        // stop while still computing is ignored
        tag = "R9";
        @(negedge clk); ref_i = 12'd50; duty_i = 10'h007; light_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check("R9", "early stop ignored", int'(busy_o), 1);
        check("R9", "early stop ref", int'(ref_o), 55);
        repeat (2) @(negedge clk);
        end_cal(50, 16);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule